// File: doc/BRIEF.md
# Reloading Down-Counter Timer

This block is a 32-bit down counter behind a small word-addressed register bus. Software sets a starting value and turns the timer on. The count then drops by one on each strobe from the tick source it has selected. When the count reaches zero, the block raises a level interrupt that stays high until software writes to the clear register. Two tick strobes come in from outside as single-cycle enables. One is slow, nominally 2 kHz. The other is fast, nominally 508 kHz. A control bit picks which one drives the count.

In continuous mode, the tick after the count reaches zero reloads the starting value. This gives a periodic interrupt. In one-shot mode, the count stays at zero. A write to the starting-value register also overwrites the running count at once, even while the timer is counting. The interrupt has no mask bit: the output always follows the expiry flag.

Top module: `tick_down_timer`

## Requirements
- R1: After reset, the load, count and control registers read zero, the timer is disabled and irq_o is low.
- R2: A write to byte offset 0x0 stores the data as the reload value and copies it into the count at the same clock edge, whether or not the timer is enabled. If a selected tick arrives in the same cycle, the write takes priority.
- R3: The control register sits at offset 0x8. Enable is bit 7, continuous mode is bit 6 and tick select is bit 3. Every other bit reads as zero, whatever was written.
- R4: With tick select at 0, only slow_tick_i moves the count. With tick select at 1, only fast_tick_i moves it. The other strobe has no effect.
- R5: The count changes only through a load write, or through a selected tick while the enable bit is 1.
- R6: When a selected tick takes the count from 1 to 0, the interrupt flag is set at that same edge.
- R7: In continuous mode (bit 6 = 1), a selected tick while the count is 0 reloads the count from the load register.
- R8: In one-shot mode (bit 6 = 0), the count holds at 0 on further ticks.
- R9: A write of any data to offset 0xC clears the interrupt flag. If an expiry falls in the same cycle, the flag stays set. With neither event, the flag holds its value.
- R10: Reads return the reload value at 0x0, the count at 0x4, the control bits at 0x8 and zero at 0xC. Only address bits 3:2 are decoded. Writes to 0x4 are ignored.
- R11: irq_o follows the interrupt flag on every cycle. No register bit masks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | Single-cycle strobe from the slow reference |
| fast_tick_i | input | 1 | Single-cycle strobe from the fast reference |
| addr_i | input | 4 | Byte address of the register |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the addressed register |
| irq_o | output | 1 | Level interrupt, high while the flag is set |

## Verification
The bench aims at four collisions:
- A load write in the same cycle as a selected tick. A design that gives the tick priority would show the decremented old count instead of the new value.
- An expiry in the same cycle as a clear write. A design that gives the clear priority would lose an interrupt.
- The strobe that is not selected, and ticks that arrive while the timer is disabled. A design that lets either move the count would drift against the model.
- The step after zero. A design that mixes up the two modes would either reload in one-shot mode or stall at zero in continuous mode.

A long random phase then compares every register and the interrupt against the reference model on every clock.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_CLEAR = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned IDX_LSB  = 2;
  localparam int unsigned IDX_W    = 2;

  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned MODE_BIT = 6;
  localparam int unsigned SEL_BIT  = 3;

  typedef struct packed {
    logic en;
    logic cont;
    logic fast;
  } ctrl_t;
endpackage

// File: rtl/tt_bus_decode.sv
module tt_bus_decode
  import tick_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic [DATA_W-1:0] count_i,
  input  ctrl_t             ctrl_i,
  output logic [NUM_REGS-1:0] wr_stb_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [IDX_W-1:0] idx;
  logic             addr_unused;

  assign idx = addr_i[IDX_LSB +: IDX_W];
  assign addr_unused = ^{addr_i[IDX_LSB-1:0], addr_i[ADDR_W-1:IDX_LSB+IDX_W]};

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_stb
    assign wr_stb_o[g] = we_i && (idx == IDX_W'(g));
  end

  logic [DATA_W-1:0] ctrl_word;
  always_comb begin
    ctrl_word           = '0;
    ctrl_word[EN_BIT]   = ctrl_i.en;
    ctrl_word[MODE_BIT] = ctrl_i.cont;
    ctrl_word[SEL_BIT]  = ctrl_i.fast;
  end

  always_comb begin
    unique case (reg_sel_e'(idx))
      REG_LOAD:  rdata_o = load_i;
      REG_COUNT: rdata_o = count_i;
      REG_CTRL:  rdata_o = ctrl_word;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tt_config_regs.sv
module tt_config_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_wr_i,
  input  logic              ctrl_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  ctrl_t             ctrl_wdata_i,
  output logic [DATA_W-1:0] load_o,
  output ctrl_t             ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o <= '0;
      ctrl_o <= '0;
    end else begin
      if (load_wr_i) load_o <= wdata_i;
      if (ctrl_wr_i) ctrl_o <= ctrl_wdata_i;
    end
  end
endmodule

// File: rtl/tt_count_core.sv
module tt_count_core
  import tick_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic              slow_tick_i,
  input  logic              fast_tick_i,
  input  logic              load_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] reload_i,
  output logic [DATA_W-1:0] count_o,
  output logic              expire_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic tick;
  logic at_zero;
  logic [DATA_W-1:0] count_d;

  assign tick     = ctrl_i.en && (ctrl_i.fast ? fast_tick_i : slow_tick_i);
  assign at_zero  = (count_o == '0);
  assign expire_o = tick && !load_wr_i && (count_o == ONE);

  always_comb begin
    count_d = count_o;
    if (load_wr_i) begin
      count_d = wdata_i;
    end else if (tick) begin
      if (!at_zero)         count_d = count_o - ONE;
      else if (ctrl_i.cont) count_d = reload_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_o <= '0;
    else         count_o <= count_d;
  end
endmodule

// File: rtl/tt_irq_flag.sv
module tt_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clear_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_o <= 1'b0;
    else if (expire_i) flag_o <= 1'b1;
    else if (clear_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              fast_tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_REGS-1:0] wr_stb;
  logic [DATA_W-1:0]   load_q;
  logic [DATA_W-1:0]   count_q;
  ctrl_t               ctrl_q;
  ctrl_t               ctrl_wd;
  logic                expire;
  logic                flag_q;

  assign ctrl_wd.en   = wdata_i[EN_BIT];
  assign ctrl_wd.cont = wdata_i[MODE_BIT];
  assign ctrl_wd.fast = wdata_i[SEL_BIT];

  tt_bus_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .addr_i   (addr_i),
    .we_i     (we_i),
    .load_i   (load_q),
    .count_i  (count_q),
    .ctrl_i   (ctrl_q),
    .wr_stb_o (wr_stb),
    .rdata_o  (rdata_o)
  );

  tt_config_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_wr_i    (wr_stb[REG_LOAD]),
    .ctrl_wr_i    (wr_stb[REG_CTRL]),
    .wdata_i      (wdata_i),
    .ctrl_wdata_i (ctrl_wd),
    .load_o       (load_q),
    .ctrl_o       (ctrl_q)
  );

  tt_count_core #(.DATA_W(DATA_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl_q),
    .slow_tick_i (slow_tick_i),
    .fast_tick_i (fast_tick_i),
    .load_wr_i   (wr_stb[REG_LOAD]),
    .wdata_i     (wdata_i),
    .reload_i    (load_q),
    .count_o     (count_q),
    .expire_o    (expire)
  );

  tt_irq_flag u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .clear_i  (wr_stb[REG_CLEAR]),
    .flag_o   (flag_q)
  );

  // count-register write strobe deliberately unused: read-only location
  logic stb_unused;
  assign stb_unused = wr_stb[REG_COUNT];

  assign irq_o = flag_q;
endmodule

// File: rtl/tt_timer_checker.sv
module tt_timer_checker
  import tick_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slow_tick_i,
  input logic              fast_tick_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_i,
  input logic [DATA_W-1:0] count_i,
  input logic [DATA_W-1:0] load_i,
  input ctrl_t             ctrl_i,
  input logic              irq_i
);
  logic [IDX_W-1:0] idx;
  logic ld_wr, clr_wr, sel_tick;
  logic [DATA_W-1:0] ctrl_mask;

  assign idx      = addr_i[IDX_LSB +: IDX_W];
  assign ld_wr    = we_i && (idx == IDX_W'(REG_LOAD));
  assign clr_wr   = we_i && (idx == IDX_W'(REG_CLEAR));
  assign sel_tick = ctrl_i.fast ? fast_tick_i : slow_tick_i;

  always_comb begin
    ctrl_mask           = '1;
    ctrl_mask[EN_BIT]   = 1'b0;
    ctrl_mask[MODE_BIT] = 1'b0;
    ctrl_mask[SEL_BIT]  = 1'b0;
  end

  assert_load_forces_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_wr |=> count_i == $past(wdata_i));

  assert_ctrl_spare_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx == IDX_W'(REG_CTRL)) |-> ((rdata_i & ctrl_mask) == '0));

  assert_hold_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.en && !ld_wr) |=> $stable(count_i));

  assert_expiry_sets_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.en && sel_tick && !ld_wr && count_i == DATA_W'(1)) |=> irq_i);

  assert_rise_needs_expiry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(count_i) == DATA_W'(1));

  assert_periodic_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.en && ctrl_i.cont && sel_tick && !ld_wr && count_i == '0)
      |=> count_i == $past(load_i));

  assert_oneshot_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.cont && !ld_wr && count_i == '0) |=> count_i == '0);

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !clr_wr) |=> irq_i);

  assert_clear_reads_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx == IDX_W'(REG_CLEAR)) |-> rdata_i == '0);
endmodule

bind tick_down_timer tt_timer_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slow_tick_i (slow_tick_i),
  .fast_tick_i (fast_tick_i),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .wdata_i     (wdata_i),
  .rdata_i     (rdata_o),
  .count_i     (count_q),
  .load_i      (load_q),
  .ctrl_i      (ctrl_q),
  .irq_i       (irq_o)
);

// File: tb/tb_tick_down_timer.sv
`timescale 1ns/1ps
module tb_tick_down_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0, fast_tick = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tick_down_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow_tick), .fast_tick_i(fast_tick),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_load, m_cnt;
  bit m_en, m_cont, m_fast, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_load = 0; m_cnt = 0; m_en = 0; m_cont = 0; m_fast = 0; m_irq = 0;
    end else begin
      bit t, ld, expd;
      int slot;
      slot = int'(addr[3:2]);
      t = m_en && (m_fast ? fast_tick : slow_tick);
      ld = we && slot == 0;
      expd = 0;
      if (ld) m_cnt = wdata;
      else if (t) begin
        if (m_cnt == 0) begin
          if (m_cont) m_cnt = m_load;
        end else begin
          if (m_cnt == 1) expd = 1;
          m_cnt = m_cnt - 1;
        end
      end
      if (expd) m_irq = 1;
      else if (we && slot == 3) m_irq = 0;
      if (ld) m_load = wdata;
      if (we && slot == 2) begin
        m_en = wdata[7]; m_cont = wdata[6]; m_fast = wdata[3];
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a[3:2])
      2'd0: return m_load;
      2'd1: return m_cnt;
      2'd2: return {24'd0, m_en, m_cont, 2'b00, m_fast, 3'b000};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // one clock: drive, wait for edge, compare with model (R10 read, R11 irq)
  task automatic cyc(input bit s, input bit f, input bit w, input logic [3:0] a,
                     input logic [31:0] d);
    slow_tick = s; fast_tick = f; we = w; addr = a; wdata = d;
    @(posedge clk); #1;
    chk("R11 irq lockstep", {31'd0, irq}, {31'd0, m_irq});
    chk("R10 rdata lockstep", rdata, m_read(a));
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    cyc(0, 0, 0, a, 0);
    chk(tag, rdata, exp);
  endtask

  task automatic irq_is(input string tag, input bit exp);
    chk(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd("R1 load", 4'h0, 0); rd("R1 count", 4'h4, 0);
    rd("R1 ctrl", 4'h8, 0); rd("R1 clear", 4'hC, 0);
    irq_is("R1 irq", 0);
    // R3 control field layout
    cyc(0, 0, 1, 4'h8, 32'hFFFF_FFFF);
    rd("R3 ctrl bits", 4'h8, 32'h0000_00C8);
    cyc(0, 0, 1, 4'h8, 0);
    rd("R3 ctrl off", 4'h8, 0);
    // R2 load copies into count, R10 count read-only, low address bits ignored
    cyc(0, 0, 1, 4'h0, 5);
    rd("R2 count after load", 4'h4, 5);
    rd("R10 load at 0x0", 4'h0, 5);
    cyc(0, 0, 1, 4'h4, 99);
    rd("R10 write 0x4 ignored", 4'h4, 5);
    rd("R10 alias 0x6", 4'h6, 5);
    // one-shot, fast select
    cyc(0, 0, 1, 4'h8, 32'h88);
    cyc(1, 0, 0, 4'h4, 0);
    chk("R4 slow ignored when fast", rdata, 5);
    for (int k = 4; k >= 0; k--) begin
      cyc(0, 1, 0, 4'h4, 0);
      chk("R5 decrement", rdata, k);
    end
    irq_is("R6 expiry irq", 1);
    cyc(0, 1, 0, 4'h4, 0);
    chk("R8 one-shot holds", rdata, 0);
    irq_is("R9 flag held", 1);
    cyc(0, 0, 1, 4'hC, 0);
    irq_is("R9 clear", 0);
    rd("R10 clear reads zero", 4'hC, 0);
    // continuous, slow select
    cyc(0, 0, 1, 4'h8, 32'hC0);
    cyc(0, 0, 1, 4'h0, 2);
    cyc(1, 0, 0, 4'h4, 0); chk("R5 cont dec", rdata, 1);
    cyc(1, 0, 0, 4'h4, 0); chk("R6 cont zero", rdata, 0);
    irq_is("R6 cont irq", 1);
    cyc(1, 0, 0, 4'h4, 0); chk("R7 reload", rdata, 2);
    cyc(0, 1, 0, 4'h4, 0); chk("R4 fast ignored when slow", rdata, 2);
    // R5 disabled
    cyc(0, 0, 1, 4'h8, 32'h40);
    cyc(1, 1, 0, 4'h4, 0); chk("R5 disabled hold", rdata, 2);
    // R9 expiry beats clear
    cyc(0, 0, 1, 4'hC, 32'hDEAD_BEEF);
    irq_is("R9 clear any data", 0);
    cyc(0, 0, 1, 4'h0, 1);
    cyc(0, 0, 1, 4'h8, 32'hC0);
    cyc(1, 0, 1, 4'hC, 32'h1234);
    irq_is("R9 expiry wins", 1);
    rd("R6 count zero", 4'h4, 0);
    // R2 load beats tick
    cyc(1, 0, 1, 4'h0, 7);
    rd("R2 load beats tick", 4'h4, 7);
    cyc(0, 0, 1, 4'hC, 0);
    irq_is("R11 irq follows flag", 0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit s, f, w;
      logic [3:0] a;
      logic [31:0] d;
      int r;
      s = (n % 11) == 0;
      f = (n % 3) == 0;
      r = $urandom_range(0, 99);
      w = r < 12;
      a = 4'($urandom_range(0, 15));
      d = $urandom;
      if (w && a[3:2] == 2'd0) d = 32'($urandom_range(0, 12));
      if (w && a[3:2] == 2'd2) d = $urandom | 32'h80;
      cyc(s, f, w, a, d);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule